// File: doc/BRIEF.md
# SerDes Lane Power Sequencer

This block walks a SerDes lane through its power-on and power-off handshakes without software in the loop. A one-cycle command pulse starts a fixed list of three steps. Each step reads the lane's configuration register, changes one bit or field, writes the result back, and then reads the lane's status register until the change shows up. The block waits a fixed number of microseconds between status reads, measured in clock cycles. If the change has not appeared after a bounded number of reads, the sequence stops and the block reports which step failed.

Register traffic goes out on a simple request/acknowledge port. The request carries the lane's management address, a register number, a write flag and write data, and the attached bus master returns read data together with its acknowledge. The serial framing of the management bus is handled outside the block. A lane management address of zero means no lane is present. In that case both commands finish at once with success. In normal use the address is 0x15.

Top module: `serdes_pwr_seq`

## Requirements
- R1: After reset, busy, done, err and reg_req are low and err_step is 0. reg_req is never high while busy is low.
- R2: Power-up runs three steps in this order: set configuration bit 0 (clock request), set configuration bit 2 (lane reset), then write 0 into configuration bits 6:4 (power state P0). Each step must be seen in the status register before the next step starts.
- R3: Power-down runs three steps in this order: write 3 into bits 6:4 (power state P3), clear bit 0, then clear bit 2. Each step must be seen in the status register before the next step starts.
- R4: Every change is a read of configuration register 0xB followed by a write to 0xB. The write alters only the targeted bit or field and keeps every other bit as it was read. Writes only ever go to 0xB.
- R5: Polls read status register 0x5. A poll succeeds when (status AND mask) equals (target AND mask). Consecutive polls of the same step are at least CLK_MHZ*POLL_US cycles apart.
- R6: If RETRIES polls of one step all fail, the sequence aborts and issues no further writes. The block then raises err and sets err_step to 1 for the clock step, 2 for the reset step or 3 for the power-state step.
- R7: With lane_addr equal to 0, a command raises done for one cycle on the next cycle, with err low. No register access is made and busy stays low.
- R8: A command that arrives while busy is ignored. If up_cmd and down_cmd arrive together, power-up is performed.
- R9: done is a one-cycle pulse at the end of every command. err and err_step hold their values until the next command is accepted, and that command clears them.
- R10: Every access carries the lane address latched at the command. reg_req, reg_addr, reg_we and reg_wdata stay stable until reg_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_cmd | input | 1 | Power-up command pulse |
| down_cmd | input | 1 | Power-down command pulse |
| lane_addr | input | ADDR_W | Lane management address, 0 = no lane |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command timed out |
| err_step | output | 2 | Failing step: 1 clock, 2 reset, 3 power state |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | Access is a write |
| reg_phy | output | ADDR_W | Lane management address of the access |
| reg_addr | output | REG_W | Register number |
| reg_wdata | output | DATA_W | Write data |
| reg_ack | input | 1 | Access complete |
| reg_rdata | input | DATA_W | Read data, valid with reg_ack |

## Verification
The bench lets the lane model show each change after a random delay. It can also hold one field stuck at the opposite of its target, so that every step in both directions can time out.

The corner cases it targets are these:
- **Stuck field.** A design that kept writing after a timeout, or that reported the wrong step, would show an extra write or a wrong err_step.
- **Unrelated configuration bits.** These bits are randomised, so a write that rebuilt the register from constants would corrupt them.
- **Poll count and spacing.** Status reads are counted and their spacing measured, which catches an off-by-one retry limit or a missing wait.
- **Command overlap.** A second command during a sequence, and both commands in the same cycle, would show up as writes out of order.
- **Zero address.** Any register traffic, or a late done, is flagged.

// File: rtl/serdes_pwr_seq.sv
module serdes_pwr_seq #(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 5,
  parameter int REG_W   = 5,
  parameter int CLK_MHZ = 100,
  parameter int POLL_US = 8,
  parameter int RETRIES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_cmd,
  input  logic              down_cmd,
  input  logic [ADDR_W-1:0] lane_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [1:0]        err_step,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_phy,
  output logic [REG_W-1:0]  reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_ack,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int GAP   = CLK_MHZ * POLL_US;
  localparam int TRY_W = $clog2(RETRIES + 1);
  localparam int GAP_W = $clog2(GAP + 1);
  localparam logic [REG_W-1:0] CFG_REG = REG_W'(11);
  localparam logic [REG_W-1:0] STS_REG = REG_W'(5);
  localparam int CLK_BIT = 0;
  localparam int RST_BIT = 2;
  localparam int PWR_LSB = 4;
  localparam logic [2:0] PWR_ON  = 3'd0;
  localparam logic [2:0] PWR_OFF = 3'd3;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WR, S_POLL, S_GAP} state_t;

  state_t            state;
  logic              dir_up;
  logic [1:0]        idx;
  logic [TRY_W-1:0]  tries;
  logic [GAP_W-1:0]  gap;
  logic [DATA_W-1:0] shadow;
  logic [1:0]        kind;
  logic [DATA_W-1:0] mask, setv;
  logic              match;

  assign kind = dir_up ? idx : ((idx == 2'd0) ? 2'd2 : idx - 2'd1);

  always_comb begin
    mask = '0;
    setv = '0;
    case (kind)
      2'd0: begin
        mask[CLK_BIT] = 1'b1;
        setv[CLK_BIT] = dir_up;
      end
      2'd1: begin
        mask[RST_BIT] = 1'b1;
        setv[RST_BIT] = dir_up;
      end
      default: begin
        mask[PWR_LSB +: 3] = 3'b111;
        setv[PWR_LSB +: 3] = dir_up ? PWR_ON : PWR_OFF;
      end
    endcase
  end

  assign match     = ((reg_rdata ^ setv) & mask) == '0;
  assign busy      = state != S_IDLE;
  assign reg_req   = state == S_RD || state == S_WR || state == S_POLL;
  assign reg_we    = state == S_WR;
  assign reg_addr  = (state == S_POLL) ? STS_REG : CFG_REG;
  assign reg_wdata = shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      dir_up   <= 1'b0;
      idx      <= '0;
      tries    <= '0;
      gap      <= '0;
      shadow   <= '0;
      reg_phy  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_step <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (up_cmd || down_cmd) begin
          err      <= 1'b0;
          err_step <= '0;
          dir_up   <= up_cmd;
          reg_phy  <= lane_addr;
          idx      <= '0;
          if (lane_addr == '0) done <= 1'b1;
          else state <= S_RD;
        end
        S_RD: if (reg_ack) begin
          shadow <= (reg_rdata & ~mask) | (setv & mask);
          state  <= S_WR;
        end
        S_WR: if (reg_ack) begin
          tries <= '0;
          state <= S_POLL;
        end
        S_POLL: if (reg_ack) begin
          if (match) begin
            if (idx == 2'd2) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              idx   <= idx + 2'd1;
              state <= S_RD;
            end
          end else if (tries == TRY_W'(RETRIES - 1)) begin
            err      <= 1'b1;
            err_step <= kind + 2'd1;
            done     <= 1'b1;
            state    <= S_IDLE;
          end else begin
            tries <= tries + 1'b1;
            gap   <= '0;
            state <= S_GAP;
          end
        end
        S_GAP: if (gap == GAP_W'(GAP - 1)) state <= S_POLL;
               else gap <= gap + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !reg_req);
  p_write_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_we |-> reg_addr == CFG_REG);
  p_retry_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TRY_W'(RETRIES));
  p_err_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> err_step != 2'd0);
  p_zero_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (up_cmd || down_cmd) && lane_addr == '0 |=> done && !err && !busy);
  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || $stable(dir_up));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !reg_req);
  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));
endmodule

// File: tb/serdes_pwr_seq_test.sv
module serdes_pwr_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ = 2;
  localparam int POLL_US = 8;
  localparam int RETRIES = 10;
  localparam int GAP = CLK_MHZ * POLL_US;
  localparam logic [4:0] LANE = 5'h15;

  logic clk = 0, rst_n = 0, up_cmd = 0, down_cmd = 0;
  logic [4:0] lane_addr = LANE;
  logic busy, done, err, reg_req, reg_we, reg_ack = 0;
  logic [1:0] err_step;
  logic [4:0] reg_phy, reg_addr;
  logic [15:0] reg_wdata, reg_rdata = 0;

  serdes_pwr_seq #(.CLK_MHZ(CLK_MHZ), .POLL_US(POLL_US), .RETRIES(RETRIES)) uut (
    .clk(clk), .rst_n(rst_n), .up_cmd(up_cmd), .down_cmd(down_cmd), .lane_addr(lane_addr),
    .busy(busy), .done(done), .err(err), .err_step(err_step), .reg_req(reg_req),
    .reg_we(reg_we), .reg_phy(reg_phy), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] kind_at(input logic up, input int i);
    if (up) return 2'(i);
    return (i == 0) ? 2'd2 : 2'(i - 1);
  endfunction
  function automatic logic [15:0] fmask(input logic [1:0] k);
    return (k == 0) ? 16'h0001 : (k == 1) ? 16'h0004 : 16'h0070;
  endfunction
  function automatic logic [15:0] fval(input logic up, input logic [1:0] k);
    if (k == 0) return up ? 16'h0001 : 16'h0000;
    if (k == 1) return up ? 16'h0004 : 16'h0000;
    return up ? 16'h0000 : 16'h0030;
  endfunction
  function automatic logic [15:0] apply(input logic [15:0] c, input logic up, input logic [1:0] k);
    return (c & ~fmask(k)) | fval(up, k);
  endfunction

  logic [15:0] cfg, sts, stuck_mask, stuck_val;
  logic [15:0] exp_w [3];
  int n_exp, wcnt, acc_cnt, sts_since_wr, lag, lagcnt, last_sts;
  string dtag;

  always @(posedge clk) begin
    cyc++;
    reg_ack <= 1'b0;
    if (lagcnt != 0) lagcnt <= lagcnt - 1;
    else sts <= cfg;
    if (reg_req && !reg_ack) begin
      reg_ack <= 1'b1;
      acc_cnt++;
      check(reg_phy == LANE, "R10 lane address", reg_phy, LANE);
      if (reg_we) begin
        check(reg_addr == 5'hB, "R4 write register", reg_addr, 5'hB);
        check(wcnt < n_exp, "R6 write after abort", wcnt, n_exp);
        if (wcnt < n_exp)
          check(reg_wdata == exp_w[wcnt], {dtag, " R4 write value"}, reg_wdata, exp_w[wcnt]);
        wcnt++;
        cfg <= reg_wdata;
        lagcnt <= lag;
        sts_since_wr = 0;
      end else if (reg_addr == 5'h5) begin
        if (sts_since_wr > 0)
          check(cyc - last_sts >= GAP, "R5 poll spacing", cyc - last_sts, GAP);
        sts_since_wr++;
        last_sts = cyc;
        reg_rdata <= (sts & ~stuck_mask) | (stuck_val & stuck_mask);
      end else begin
        check(reg_addr == 5'hB, "R4 read register", reg_addr, 5'hB);
        reg_rdata <= cfg;
      end
    end
  end

  task automatic run_trial(input logic up, input logic both, input logic intr,
                           input logic [15:0] start, input int s, input int lg);
    logic [15:0] cur;
    logic [1:0] sk;
    @(negedge clk);
    dtag = up ? "R2" : "R3";
    cfg = start; sts = start; lag = lg; lagcnt = 0;
    wcnt = 0; acc_cnt = 0; sts_since_wr = 0; n_exp = 0;
    stuck_mask = 0; stuck_val = 0;
    if (s < 3) begin
      sk = 2'(s);
      stuck_mask = fmask(sk);
      stuck_val = fval(up, sk) ^ fmask(sk);
    end
    cur = start;
    for (int i = 0; i < 3; i++) begin
      cur = apply(cur, up, kind_at(up, i));
      exp_w[i] = cur;
      n_exp++;
      if (s < 3 && kind_at(up, i) == 2'(s)) break;
    end
    up_cmd = up | both; down_cmd = ~up | both;
    @(negedge clk);
    up_cmd = 0; down_cmd = 0;
    check(busy && !err && err_step == 0, "R9 command clears error", {busy, err, err_step}, 4'b1000);
    for (int i = 0; i < 6000; i++) begin
      if (intr && i == 5) begin up_cmd = ~up; down_cmd = up; end
      if (intr && i == 6) begin up_cmd = 0; down_cmd = 0; end
      if (done) break;
      @(negedge clk);
    end
    check(done, {dtag, " R9 done reached"}, done, 1);
    check(err == (s < 3), "R6 err flag", err, s < 3);
    check(err_step == ((s < 3) ? 2'(s + 1) : 2'd0), "R6 err_step", err_step, (s < 3) ? s + 1 : 0);
    check(wcnt == n_exp, {dtag, " R6 write count"}, wcnt, n_exp);
    check(cfg == exp_w[n_exp-1], {dtag, " R4 final config"}, cfg, exp_w[n_exp-1]);
    if (s < 3) check(sts_since_wr == RETRIES, "R6 poll count", sts_since_wr, RETRIES);
    @(negedge clk);
    check(!done && !busy, "R9 done one cycle", {done, busy}, 0);
    if (s < 3) begin
      repeat (20) @(negedge clk);
      check(err && err_step == 2'(s + 1), "R9 error held", err_step, s + 1);
    end
  endtask

  task automatic zero_cmd(input logic up);
    @(negedge clk);
    acc_cnt = 0;
    lane_addr = 0;
    up_cmd = up; down_cmd = ~up;
    @(negedge clk);
    up_cmd = 0; down_cmd = 0;
    check(done && !err && !busy, "R7 immediate done", {done, err, busy}, 4);
    repeat (5) @(negedge clk);
    check(acc_cnt == 0 && !done, "R7 no access", acc_cnt, 0);
    lane_addr = LANE;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    cfg = 0; sts = 0; stuck_mask = 0; stuck_val = 0; lag = 0; lagcnt = 0;
    n_exp = 0; wcnt = 0; acc_cnt = 0; sts_since_wr = 0; last_sts = 0; dtag = "R2";
    repeat (3) @(negedge clk);
    check(!busy && !done && !err && err_step == 0 && !reg_req, "R1 reset state",
          {busy, done, err, err_step, reg_req}, 0);
    rst_n = 1;
    zero_cmd(1);
    zero_cmd(0);
    run_trial(1, 0, 0, 16'h0030, 3, 3);
    run_trial(0, 0, 0, 16'hA005, 3, 7);
    run_trial(1, 0, 0, 16'h1230, 0, 0);
    run_trial(1, 0, 0, 16'h0030, 2, 4);
    run_trial(0, 0, 0, 16'h0005, 2, 2);
    run_trial(0, 0, 0, 16'h0005, 1, 2);
    run_trial(1, 0, 1, 16'hF0F8, 3, 30);
    run_trial(1, 1, 0, 16'h0C30, 3, 10);
    run_trial(1, 0, 0, 16'h0030, 3, 90);
    for (int t = 0; t < 40; t++) begin
      int r = $urandom % 6;
      run_trial(1'($urandom), 0, 1'($urandom % 4 == 0), 16'($urandom),
                (r < 3) ? r : 3, $urandom % 91);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule